// File: doc/BRIEF.md
# Nibble-Serial Indirect Register Writer

This block writes one byte to a register that sits behind a 16-bit extended address, on a target port that only understands two kinds of command cycle. An address command carries a 6-bit pointer. A data command carries a 4-bit nibble. The master asserts a start request with the extended address and the byte. The block then issues a fixed nine-command sequence in three groups.

1. It selects the low-address pointer and sends the low address byte.
2. It selects the high-address pointer and sends the high address byte.
3. It selects the data-window pointer and sends the value byte.

Each byte goes out as its upper nibble followed by its lower nibble.

Every command is offered with a valid flag and held until the target accepts it with a ready handshake. A single-cycle done pulse follows acceptance of the final nibble. While a sequence is running, the block ignores further start requests and any change on its request inputs. For example, writing 0x1C to extended address 0xE609 produces this command stream: address 0x3A, data 0x0, data 0x9, address 0x3B, data 0xE, data 0x6, address 0x3C, data 0x1, data 0xC.

Top module: `nibble_reg_writer`

## Requirements
- R1: After reset, `busy`, `cmdValid` and `done` are all low.
- R2: When idle, a high `startReq` captures `startAddr` and `startData` at the clock edge. From the next cycle, `busy` and `cmdValid` are high and the first command is offered.
- R3: While `cmdValid` is high and `cmdReady` is low, `cmdValid`, `cmdIsAddr` and `cmdWord` all hold their values into the next cycle.
- R4: Address commands have `cmdIsAddr` = 1 and carry a 6-bit pointer in `cmdWord`: 0x3A selects the low address byte, 0x3B the high address byte and 0x3C the data window. Data commands have `cmdIsAddr` = 0, carry the nibble in `cmdWord[3:0]`, and have `cmdWord[5:4]` = 0.
- R5: The accepted command order is fixed: 0x3A, addr[7:4], addr[3:0], 0x3B, addr[15:12], addr[11:8], 0x3C, data[7:4], data[3:0].
- R6: In the cycle after the ninth command is accepted, `done` is high and `busy` is low. `done` is high for exactly one cycle.
- R7: A `startReq` raised while `busy` is high is ignored. The running sequence keeps its captured values, and no extra sequence follows.
- R8: Changes on `startAddr` and `startData` after capture do not affect the commands emitted.
- R9: With `cmdReady` held high, a transfer occupies exactly nine command cycles, and `done` rises ten cycles after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request a transfer (taken only when idle) |
| startAddr | input | 16 | Extended target address |
| startData | input | 8 | Byte to write |
| cmdReady | input | 1 | Target accepts the offered command |
| cmdValid | output | 1 | A command is offered |
| cmdIsAddr | output | 1 | 1 = address command, 0 = data command |
| cmdWord | output | 6 | Pointer (address command) or zero-extended nibble (data command) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after the last nibble is accepted |

## Verification
The assertions check the following on every cycle:
- an offered command stays stable under backpressure;
- address commands only ever carry one of the three pointers, and data commands keep their top bits clear;
- no command is offered while idle;
- `done` is a single-cycle pulse that is always preceded by an accepted command.

Only the bench's scenarios can show the exact nine-step order and nibble values for a given address and byte, the count of ten cycles to `done`, and the fact that a mid-sequence start request or input change leaves the emitted stream untouched.

// File: rtl/niw_pkg.sv
package niw_pkg;
  localparam int STEPS  = 9;
  localparam int STEP_W = $clog2(STEPS);

  typedef struct packed {
    logic              load;
    logic [STEP_W-1:0] step;
  } niwStrobe_t;
endpackage

// File: rtl/niw_ctrl.sv
module niw_ctrl
  import niw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       cmdReady,
  output niwStrobe_t strobe,
  output logic       cmdValid,
  output logic       busy,
  output logic       done
);
  typedef enum logic {IDLE, RUN} state_t;

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

  state_t            stateQ;
  logic [STEP_W-1:0] stepQ;
  logic              doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= IDLE;
      stepQ  <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (stateQ)
        IDLE: if (startReq) begin
          stateQ <= RUN;
          stepQ  <= '0;
        end
        RUN: if (cmdReady) begin
          if (stepQ == LAST_STEP) begin
            stateQ <= IDLE;
            doneQ  <= 1'b1;
          end else begin
            stepQ <= stepQ + 1'b1;
          end
        end
        default: stateQ <= IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load = (stateQ == IDLE) && startReq;
    strobe.step = stepQ;
  end

  assign cmdValid = (stateQ == RUN);
  assign busy     = (stateQ == RUN);
  assign done     = doneQ;
endmodule

// File: rtl/niw_datapath.sv
module niw_datapath
  import niw_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter int          DATA_W  = 8,
  parameter int          PTR_W   = 6,
  parameter int          NIB_W   = 4,
  parameter logic [5:0]  PTR_LO  = 6'h3A,
  parameter logic [5:0]  PTR_HI  = 6'h3B,
  parameter logic [5:0]  PTR_WIN = 6'h3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  niwStrobe_t        strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] startData,
  output logic              cmdIsAddr,
  output logic [PTR_W-1:0]  cmdWord
);
  localparam int GROUPS = 3;
  localparam int PAD_W  = PTR_W - NIB_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (strobe.load) begin
      addrQ <= startAddr;
      dataQ <= startData;
    end
  end

  logic [7:0]       grpByte [GROUPS];
  logic [PTR_W-1:0] grpPtr  [GROUPS];

  always_comb begin
    grpByte[0] = addrQ[7:0];
    grpByte[1] = addrQ[15:8];
    grpByte[2] = dataQ[7:0];
    grpPtr[0]  = PTR_W'(PTR_LO);
    grpPtr[1]  = PTR_W'(PTR_HI);
    grpPtr[2]  = PTR_W'(PTR_WIN);
  end

  int unsigned grpIdx;
  int unsigned phase;

  always_comb begin
    grpIdx    = 32'(strobe.step) / GROUPS;
    phase     = 32'(strobe.step) % GROUPS;
    cmdIsAddr = 1'b0;
    cmdWord   = '0;
    if (grpIdx < GROUPS) begin
      case (phase)
        0: begin
          cmdIsAddr = 1'b1;
          cmdWord   = grpPtr[grpIdx];
        end
        1:       cmdWord = {{PAD_W{1'b0}}, grpByte[grpIdx][7:4]};
        default: cmdWord = {{PAD_W{1'b0}}, grpByte[grpIdx][3:0]};
      endcase
    end
  end
endmodule

// File: rtl/nibble_reg_writer.sv
module nibble_reg_writer
  import niw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic [15:0] startAddr,
  input  logic [7:0]  startData,
  input  logic        cmdReady,
  output logic        cmdValid,
  output logic        cmdIsAddr,
  output logic [5:0]  cmdWord,
  output logic        busy,
  output logic        done
);
  niwStrobe_t strobe;

  niw_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .cmdReady (cmdReady),
    .strobe   (strobe),
    .cmdValid (cmdValid),
    .busy     (busy),
    .done     (done)
  );

  niw_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .startAddr (startAddr),
    .startData (startData),
    .cmdIsAddr (cmdIsAddr),
    .cmdWord   (cmdWord)
  );
endmodule

// File: rtl/nibble_reg_writer_checker.sv
module nibble_reg_writer_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cmdReady,
  input logic       cmdValid,
  input logic       cmdIsAddr,
  input logic [5:0] cmdWord,
  input logic       busy,
  input logic       done
);
  // R3: command held under backpressure
  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdWord) && $stable(cmdIsAddr));

  // R4: pointer set limited to three values
  p_addr_ptr_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdIsAddr |-> (cmdWord == 6'h3A || cmdWord == 6'h3B || cmdWord == 6'h3C));

  // R4: data commands keep the pad bits clear
  p_nibble_pad_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdIsAddr |-> cmdWord[5:4] == 2'b00);

  // R6: done lasts a single cycle
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: done follows an accepted command, with busy low
  p_done_after_accept_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(cmdValid && cmdReady) && !busy);

  // R1: nothing offered while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !cmdValid);
endmodule

bind nibble_reg_writer nibble_reg_writer_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cmdReady  (cmdReady),
  .cmdValid  (cmdValid),
  .cmdIsAddr (cmdIsAddr),
  .cmdWord   (cmdWord),
  .busy      (busy),
  .done      (done)
);

// File: tb/nibble_reg_writer_test.sv
module nibble_reg_writer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [15:0] startAddr = '0;
  logic [7:0]  startData = '0;
  logic        cmdReady = 1'b0;
  logic        cmdValid, cmdIsAddr, busy, done;
  logic [5:0]  cmdWord;

  int testCount = 0;
  int failCount = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  nibble_reg_writer uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startAddr(startAddr),
    .startData(startData), .cmdReady(cmdReady), .cmdValid(cmdValid),
    .cmdIsAddr(cmdIsAddr), .cmdWord(cmdWord), .busy(busy), .done(done)
  );

  localparam int NVEC = 5;
  localparam logic [23:0] VEC [NVEC] = '{
    24'hE609_1C, 24'h0000_00, 24'hFFFF_FF, 24'h1234_A5, 24'h8001_7E
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] expCmd(input int i, input logic [15:0] a, input logic [7:0] d);
    case (i)
      0: return {1'b1, 6'h3A};
      1: return {3'b000, a[7:4]};
      2: return {3'b000, a[3:0]};
      3: return {1'b1, 6'h3B};
      4: return {3'b000, a[15:12]};
      5: return {3'b000, a[11:8]};
      6: return {1'b1, 6'h3C};
      7: return {3'b000, d[7:4]};
      default: return {3'b000, d[3:0]};
    endcase
  endfunction

  // stall: insert backpressure; disturb: poke startReq and inputs mid-run
  task automatic runXfer(input logic [15:0] a, input logic [7:0] d, input bit stall, input bit disturb);
    logic [6:0] held;
    @(negedge clk);
    startReq = 1'b1; startAddr = a; startData = d; cmdReady = 1'b0;
    @(negedge clk);
    startReq = 1'b0;
    check("R2 busy after start", {31'd0, busy}, 32'd1);
    if (disturb) begin startAddr = ~a; startData = ~d; end  // R8
    for (int i = 0; i < 9; i++) begin
      int stalls = stall ? (i % 3) : 0;
      if (stalls > 0) begin
        held = {cmdIsAddr, cmdWord};
        for (int s = 0; s < stalls; s++) begin
          @(negedge clk);
          check("R3 held under stall", {25'd0, cmdIsAddr, cmdWord}, {25'd0, held});
        end
      end
      cmdReady = 1'b1;
      check("R2 cmdValid", {31'd0, cmdValid}, 32'd1);
      check(disturb ? "R7 R8 sequence" : "R4 R5 sequence",
            {25'd0, cmdIsAddr, cmdWord}, {25'd0, expCmd(i, a, d)});
      if (disturb && i == 4) startReq = 1'b1;  // R7
      @(negedge clk);
      startReq = 1'b0;
      if (stall) cmdReady = 1'b0;
      if (i < 8) check("R9 no early done", {31'd0, done}, 32'd0);
    end
    check("R6 done high", {31'd0, done}, 32'd1);
    check("R6 busy low", {31'd0, busy}, 32'd0);
    cmdReady = 1'b0;
    @(negedge clk);
    check("R6 done one cycle", {31'd0, done}, 32'd0);
    check("R7 no extra sequence", {31'd0, cmdValid}, 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failCount++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy reset", {31'd0, busy}, 32'd0);
    check("R1 valid reset", {31'd0, cmdValid}, 32'd0);
    check("R1 done reset", {31'd0, done}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    cmdReady = 1'b1;  // ready while idle must do nothing
    @(negedge clk);
    check("R1 idle with ready", {31'd0, cmdValid}, 32'd0);
    for (int v = 0; v < NVEC; v++)
      runXfer(VEC[v][23:8], VEC[v][7:0], v[0], 1'b0);
    runXfer(16'hE609, 8'h1C, 1'b0, 1'b1);
    runXfer(16'h5AC3, 8'h96, 1'b1, 1'b1);
    // reset in the middle of a transfer returns to idle
    @(negedge clk);
    startReq = 1'b1; startAddr = 16'h1111; startData = 8'h22;
    @(negedge clk);
    startReq = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", {30'd0, busy, cmdValid}, 32'd0);
    rstN = 1'b1;
    runXfer(16'hABCD, 8'hEF, 1'b0, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule